// File: doc/BRIEF.md
# Standard-Definition Sync and Field Decoder

This block sits at the timing input of a standard-definition video encoder. It reads an active-low horizontal sync. It also reads one vertical timing signal, which depending on the mode is either a field-level input or an active-low vertical sync. A 3-bit timing-mode code chooses how the vertical signal is read, and a standard-select input chooses 525-line or 625-line timing.

From these inputs the block works out where fields and frames begin and whether the current field is odd or even. It keeps a line number, marks the lines of the vertical interval as blanked, and gives a one-cycle pixel-capture strobe a fixed number of clocks after each horizontal sync fall.

Field identity in sync mode comes from how the vertical sync fall lines up with the horizontal sync. A fall in the same clock as the horizontal fall starts an odd field. A fall while the horizontal sync is high starts an even field. The downstream pixel path uses the capture strobe to latch data. It uses the blank flag and the field flag to route or suppress lines.

Top module: `sd_sync_field_decoder`

## Requirements
- R1: After reset, with a valid mode code, line_o reads 1, field_o, field_start_o, frame_start_o and cap_o are 0, and blank_o is 1.
- R2: With mode code 3'b011 (field-input timing), a change of vsig_i while hsync_ni is low starts a field. field_o takes the new vsig_i level, where 0 means odd and 1 means even. A change to 0 also pulses frame_start_o and loads line 1. A change to 1 loads line 264 when pal_i=0 and line 313 when pal_i=1.
- R3: With mode code 3'b100 (sync timing), a vsig_i fall in the same clock as an hsync_ni fall starts an odd field. It sets field_o to 0, pulses frame_start_o together with field_start_o, and loads line 1.
- R4: With mode code 3'b100, a vsig_i fall while hsync_ni is high starts an even field. It sets field_o to 1, pulses field_start_o without frame_start_o, and loads line 264 (pal_i=0) or line 313 (pal_i=1).
- R5: Every other hsync_ni fall advances line_o by one. The count goes from 525 to 1 when pal_i=0 and from 625 to 1 when pal_i=1, and line_o is never 0.
- R6: blank_o is 1 exactly on lines 1–21 and 264–283 when pal_i=0, and on lines 1–22 and 311–335 when pal_i=1.
- R7: If an hsync_ni fall is first sampled at clock edge e, cap_o is high for exactly one cycle, the cycle that begins at edge e+1+D. D is CAP_DLY_NTSC when pal_i=0 and CAP_DLY_PAL when pal_i=1.
- R8: Both sync inputs pass through two synchronizing flops. Field starts and line changes caused by an input edge first sampled at edge e appear after edge e+2. The exception is a field-input change, which needs hsync_ni low when the change is seen. field_start_o is high for a single cycle.
- R9: cap_o stays 0 on any line where blank_o is 1.
- R10: For any mode code other than 3'b011 or 3'b100, field_o, field_start_o, frame_start_o, blank_o and cap_o are 0, and line_o holds its value through hsync and vsig edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hsync_ni | input | 1 | Active-low horizontal sync |
| vsig_i | input | 1 | Field level (mode 011) or active-low vertical sync (mode 100) |
| mode_i | input | 3 | Timing-mode code |
| pal_i | input | 1 | 0 selects 525-line timing, 1 selects 625-line timing |
| field_o | output | 1 | Current field: 0 odd, 1 even |
| frame_start_o | output | 1 | One-cycle pulse at the start of an odd field |
| field_start_o | output | 1 | One-cycle pulse at any field start |
| line_o | output | 10 | Current line number |
| blank_o | output | 1 | Current line is in the vertical blank |
| cap_o | output | 1 | One-cycle pixel capture strobe |

## Verification
The bench builds the block with CAP_DLY_NTSC=10 and CAP_DLY_PAL=13 and keeps the default line counts. Each line can then be 24 clocks long and still hold the strobe inside it. At that length, complete 525-line and 625-line sequences in both timing modes fit in one run. This brings every blank boundary, both wrap points, both even-field load values and the odd-field coincidence within reach. It also checks the exact strobe cycle for both delays and the frozen behaviour under two invalid mode codes.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

  typedef enum logic [2:0] {
    SFD_MODE_FLD = 3'b011,
    SFD_MODE_HV  = 3'b100
  } sfd_mode_e;

endpackage

// File: rtl/sfd_sync_pair.sv
module sfd_sync_pair #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic lvl_o,
  output logic prev_o
);

  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], sig_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '1;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign prev_o = sh_q[STAGES];

endmodule

// File: rtl/sfd_field_tracker.sv
module sfd_field_tracker #(
  parameter int LINE_W        = 10,
  parameter int NTSC_LINES    = 525,
  parameter int PAL_LINES     = 625,
  parameter int NTSC_F2_LINE  = 264,
  parameter int PAL_F2_LINE   = 313,
  parameter int NTSC_BLK1_END = 21,
  parameter int NTSC_BLK2_BEG = 264,
  parameter int NTSC_BLK2_END = 283,
  parameter int PAL_BLK1_END  = 22,
  parameter int PAL_BLK2_BEG  = 311,
  parameter int PAL_BLK2_END  = 335
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              hv_i,
  input  logic              pal_i,
  input  logic              h_lvl_i,
  input  logic              h_fall_i,
  input  logic              v_lvl_i,
  input  logic              v_fall_i,
  input  logic              v_tog_i,
  output logic [LINE_W-1:0] line_o,
  output logic              field_o,
  output logic              fstart_o,
  output logic              frame_o,
  output logic              blank_o
);

  localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);
  localparam logic [LINE_W-1:0] N_TOT    = LINE_W'(NTSC_LINES);
  localparam logic [LINE_W-1:0] P_TOT    = LINE_W'(PAL_LINES);
  localparam logic [LINE_W-1:0] N_F2     = LINE_W'(NTSC_F2_LINE);
  localparam logic [LINE_W-1:0] P_F2     = LINE_W'(PAL_F2_LINE);
  localparam logic [LINE_W-1:0] N_B1E    = LINE_W'(NTSC_BLK1_END);
  localparam logic [LINE_W-1:0] N_B2B    = LINE_W'(NTSC_BLK2_BEG);
  localparam logic [LINE_W-1:0] N_B2E    = LINE_W'(NTSC_BLK2_END);
  localparam logic [LINE_W-1:0] P_B1E    = LINE_W'(PAL_BLK1_END);
  localparam logic [LINE_W-1:0] P_B2B    = LINE_W'(PAL_BLK2_BEG);
  localparam logic [LINE_W-1:0] P_B2E    = LINE_W'(PAL_BLK2_END);

  logic [LINE_W-1:0] line_q, line_d;
  logic              field_q, field_d;
  logic              fs_q, fs_d;
  logic              frm_q, frm_d;
  logic              start, odd;
  logic [LINE_W-1:0] total, second, b1e, b2b, b2e;

  always_comb begin
    total  = pal_i ? P_TOT : N_TOT;
    second = pal_i ? P_F2  : N_F2;
    b1e    = pal_i ? P_B1E : N_B1E;
    b2b    = pal_i ? P_B2B : N_B2B;
    b2e    = pal_i ? P_B2E : N_B2E;
  end

  // vertical event decode: phase of the vertical signal against hsync
  always_comb begin
    if (hv_i) begin
      start = v_fall_i & (h_fall_i | h_lvl_i);
      odd   = h_fall_i;
    end else begin
      start = v_tog_i & ~h_lvl_i;
      odd   = ~v_lvl_i;
    end
  end

  always_comb begin
    line_d  = line_q;
    field_d = field_q;
    fs_d    = 1'b0;
    frm_d   = 1'b0;
    if (start) begin
      line_d  = odd ? LINE_ONE : second;
      field_d = ~odd;
      fs_d    = 1'b1;
      frm_d   = odd;
    end else if (h_fall_i) begin
      line_d = (line_q >= total) ? LINE_ONE : line_q + LINE_ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= LINE_ONE;
      field_q <= 1'b0;
    end else if (en_i) begin
      line_q  <= line_d;
      field_q <= field_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q  <= 1'b0;
      frm_q <= 1'b0;
    end else begin
      fs_q  <= en_i & fs_d;
      frm_q <= en_i & frm_d;
    end
  end

  assign line_o   = line_q;
  assign field_o  = en_i & field_q;
  assign fstart_o = en_i & fs_q;
  assign frame_o  = en_i & frm_q;
  assign blank_o  = en_i & ((line_q <= b1e) | ((line_q >= b2b) & (line_q <= b2e)));

  assert_line_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_q != '0) && (line_q <= P_TOT));

  assert_frame_is_odd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_q |-> (!field_q && fs_q));

  assert_frame_line_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_q |-> (line_q == LINE_ONE));

  assert_line_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(line_q));

  assert_fstart_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_q |=> !fs_q);

endmodule

// File: rtl/sfd_cap_timer.sv
module sfd_cap_timer #(
  parameter int DLY_NTSC = 122,
  parameter int DLY_PAL  = 132
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pal_i,
  input  logic h_fall_i,
  input  logic blank_i,
  output logic cap_o
);

  localparam int DMAX  = (DLY_PAL > DLY_NTSC) ? DLY_PAL : DLY_NTSC;
  localparam int CNT_W = (DMAX > 2) ? $clog2(DMAX) : 1;
  localparam logic [CNT_W-1:0] LOAD_N = CNT_W'(DLY_NTSC - 1);
  localparam logic [CNT_W-1:0] LOAD_P = CNT_W'(DLY_PAL - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;
  logic             hit;

  assign hit = act_q & (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (!en_i) begin
      act_d = 1'b0;
    end else if (h_fall_i) begin
      act_d = 1'b1;
      cnt_d = pal_i ? LOAD_P : LOAD_N;
    end else if (act_q) begin
      if (cnt_q == '0) begin
        act_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign cap_o = hit & en_i & ~blank_i;

  assert_cap_not_blank_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |-> !blank_i);

  assert_cap_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |=> !cap_o);

endmodule

// File: rtl/sd_sync_field_decoder.sv
module sd_sync_field_decoder
  import sfd_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int NTSC_LINES   = 525,
  parameter int PAL_LINES    = 625,
  parameter int CAP_DLY_NTSC = 122,
  parameter int CAP_DLY_PAL  = 132,
  localparam int LINE_W      = $clog2(PAL_LINES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsync_ni,
  input  logic              vsig_i,
  input  logic [2:0]        mode_i,
  input  logic              pal_i,
  output logic              field_o,
  output logic              frame_start_o,
  output logic              field_start_o,
  output logic [LINE_W-1:0] line_o,
  output logic              blank_o,
  output logic              cap_o
);

  localparam int NSIG = 2;

  logic [NSIG-1:0] raw, lvl, prv;
  logic            mode_ok, is_hv;
  logic            h_fall, v_fall, v_tog;

  assign raw = {vsig_i, hsync_ni};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    sfd_sync_pair #(.STAGES(SYNC_STAGES)) u_pair (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sig_i  (raw[g]),
      .lvl_o  (lvl[g]),
      .prev_o (prv[g])
    );
  end

  assign is_hv   = (mode_i == SFD_MODE_HV);
  assign mode_ok = is_hv || (mode_i == SFD_MODE_FLD);
  assign h_fall  = prv[0] & ~lvl[0];
  assign v_fall  = prv[1] & ~lvl[1];
  assign v_tog   = prv[1] ^ lvl[1];

  sfd_field_tracker #(
    .LINE_W     (LINE_W),
    .NTSC_LINES (NTSC_LINES),
    .PAL_LINES  (PAL_LINES)
  ) u_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (mode_ok),
    .hv_i     (is_hv),
    .pal_i    (pal_i),
    .h_lvl_i  (lvl[0]),
    .h_fall_i (h_fall),
    .v_lvl_i  (lvl[1]),
    .v_fall_i (v_fall),
    .v_tog_i  (v_tog),
    .line_o   (line_o),
    .field_o  (field_o),
    .fstart_o (field_start_o),
    .frame_o  (frame_start_o),
    .blank_o  (blank_o)
  );

  sfd_cap_timer #(
    .DLY_NTSC (CAP_DLY_NTSC),
    .DLY_PAL  (CAP_DLY_PAL)
  ) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (mode_ok),
    .pal_i    (pal_i),
    .h_fall_i (h_fall),
    .blank_i  (blank_o),
    .cap_o    (cap_o)
  );

  assert_idle_outputs_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_ok |-> !(field_o | frame_start_o | field_start_o | blank_o | cap_o));

endmodule

// File: tb/sd_sync_field_decoder_tb_top.sv
module sd_sync_field_decoder_tb_top;

  localparam int DN = 10;
  localparam int DP = 13;
  localparam int LL = 24;
  localparam int K_PLAIN = 0, K_FLD = 1, K_HVODD = 2, K_HVEVEN = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hs_n = 1'b1;
  logic       vs = 1'b1;
  logic [2:0] mode = 3'b011;
  logic       pal = 1'b0;
  logic       field_o, frame_o, fstart_o, blank_o, cap_o;
  logic [9:0] line_o;

  always #5 clk = ~clk;

  sd_sync_field_decoder #(
    .CAP_DLY_NTSC (DN),
    .CAP_DLY_PAL  (DP)
  ) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .hsync_ni      (hs_n),
    .vsig_i        (vs),
    .mode_i        (mode),
    .pal_i         (pal),
    .field_o       (field_o),
    .frame_start_o (frame_o),
    .field_start_o (fstart_o),
    .line_o        (line_o),
    .blank_o       (blank_o),
    .cap_o         (cap_o)
  );

  typedef struct {
    int    at;
    bit    is_fs;
    bit    fld;
    bit    frm;
    int    ln;
    string tag;
  } exp_t;

  exp_t  q[$];
  int    cyc = 0;
  int    n_cmp = 0;
  int    n_bad = 0;
  int    m_line = 1;
  bit    m_field = 1'b0;
  string ftag = "R2";

  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit exp_blank(int l, bit p);
    if (p) return (l <= 22) || (l >= 311 && l <= 335);
    return (l <= 21) || (l >= 264 && l <= 283);
  endfunction

  function automatic int total_lines();
    return pal ? 625 : 525;
  endfunction

  function automatic int second_line();
    return pal ? 313 : 264;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int at, input bit is_fs, input bit fld, input bit frm,
                      input int ln, input string tag);
    exp_t e;
    e.at = at; e.is_fs = is_fs; e.fld = fld; e.frm = frm; e.ln = ln; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: pops expected events as the design produces them
  always @(negedge clk) begin
    if (rst_n) begin
      while (q.size() > 0 && q[0].at < cyc) begin
        n_cmp++; n_bad++;
        $display("FAIL %s R8 missed event actual=none expected=cycle %0d", q[0].tag, q[0].at);
        void'(q.pop_front());
      end
      if (frame_o && !fstart_o) begin
        n_cmp++; n_bad++;
        $display("FAIL R3 frame pulse alone actual=1 expected=0");
      end
      if (fstart_o) begin
        n_cmp++;
        if (q.size() == 0 || !q[0].is_fs || q[0].at != cyc) begin
          n_bad++;
          $display("FAIL R8 R10 unexpected field start actual=cycle %0d expected=none", cyc);
        end else begin
          if (field_o !== q[0].fld || frame_o !== q[0].frm || int'(line_o) != q[0].ln) begin
            n_bad++;
            $display("FAIL %s field start actual=f%0d/fr%0d/l%0d expected=f%0d/fr%0d/l%0d",
                     q[0].tag, field_o, frame_o, line_o, q[0].fld, q[0].frm, q[0].ln);
          end
          void'(q.pop_front());
        end
      end
      if (cap_o) begin
        n_cmp++;
        if (q.size() == 0 || q[0].is_fs || q[0].at != cyc) begin
          n_bad++;
          $display("FAIL R7 R9 R10 unexpected strobe actual=cycle %0d expected=cycle %0d",
                   cyc, (q.size() > 0) ? q[0].at : -1);
        end else begin
          void'(q.pop_front());
        end
      end
    end
  end

  task automatic do_line(input int kind, input bit fv);
    int n;
    int dly;
    dly = pal ? DP : DN;
    @(negedge clk);
    n = cyc;
    hs_n = 1'b0;
    if (kind == K_HVODD) vs = 1'b0;
    case (kind)
      K_FLD: begin
        m_line = fv ? second_line() : 1;
        m_field = fv;
        push(n + 4, 1'b1, fv, !fv, m_line, "R2");
      end
      K_HVODD: begin
        m_line = 1;
        m_field = 1'b0;
        push(n + 3, 1'b1, 1'b0, 1'b1, 1, "R3");
      end
      K_HVEVEN: begin
        m_line = second_line();
        m_field = 1'b1;
        push(n + 11, 1'b1, 1'b1, 1'b0, m_line, "R4");
      end
      default: m_line = (m_line >= total_lines()) ? 1 : m_line + 1;
    endcase
    if (!exp_blank(m_line, pal)) push(n + 2 + dly, 1'b0, 1'b0, 1'b0, 0, "R7");
    for (int t = 1; t < LL; t++) begin
      @(negedge clk);
      if (t == 1 && kind == K_FLD) vs = fv;
      if (t == 4) begin
        hs_n = 1'b1;
        if (kind == K_HVODD) vs = 1'b1;
      end
      if (t == 8 && kind == K_HVEVEN) vs = 1'b0;
      if (t == 12 && kind == K_HVEVEN) vs = 1'b1;
      if (t == 20) begin
        chk("R5 line", int'(line_o), m_line);
        chk("R6 blank", int'(blank_o), int'(exp_blank(m_line, pal)));
        chk({ftag, " field"}, int'(field_o), int'(m_field));
      end
    end
  endtask

  task automatic run_combo(input bit is_hv, input bit p);
    int half;
    mode = is_hv ? 3'b100 : 3'b011;
    pal = p;
    vs = 1'b1;
    hs_n = 1'b1;
    ftag = is_hv ? "R4" : "R2";
    repeat (30) @(negedge clk);
    half = second_line() - 1;
    for (int k = 0; k <= total_lines() + 2; k++) begin
      if (k == 0) do_line(is_hv ? K_HVODD : K_FLD, 1'b0);
      else if (k == half) do_line(is_hv ? K_HVEVEN : K_FLD, 1'b1);
      else do_line(K_PLAIN, 1'b0);
    end
  endtask

  task automatic bad_mode(input logic [2:0] m);
    mode = m;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      hs_n = 1'b0;
      for (int t = 1; t < LL; t++) begin
        @(negedge clk);
        if (t == 1 || t == 2) vs = ~vs;
        if (t == 4) hs_n = 1'b1;
        if (t == 20) begin
          chk("R10 line frozen", int'(line_o), m_line);
          chk("R10 field", int'(field_o), 0);
          chk("R10 blank", int'(blank_o), 0);
        end
      end
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    if (cyc == 190000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d cycles expected=done", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 line", int'(line_o), 1);
    chk("R1 field", int'(field_o), 0);
    chk("R1 blank", int'(blank_o), 1);
    chk("R1 field start", int'(fstart_o), 0);
    chk("R1 frame start", int'(frame_o), 0);
    chk("R1 strobe", int'(cap_o), 0);

    run_combo(1'b0, 1'b0);
    run_combo(1'b1, 1'b1);
    run_combo(1'b0, 1'b1);
    run_combo(1'b1, 1'b0);

    bad_mode(3'b000);
    bad_mode(3'b111);

    repeat (40) @(negedge clk);
    chk("R7 pending events", q.size(), 0);
    summary();
    $finish;
  end

endmodule